// File: doc/BRIEF.md
# SPI Serial Clock Generator with Programmable Duty

This block derives an SPI serial clock from the system clock. An integer divisor sets the length of one bit period in system cycles, and an 8-bit duty setting sets how much of that period the clock spends in its first (active) phase, in steps of 1/256 of the period. Polarity selects the level the clock rests at, and phase selects which of the two clock edges in a bit captures data and which one shifts it out.

Next to the clock, the block produces two single-cycle strobes for the transaction engine that sits beside it. The launch strobe tells the engine to present the next bit. The sample strobe tells it to capture the incoming bit. Each strobe is high in exactly the cycle in which the matching clock edge appears at the output. A new divisor, duty, polarity or phase setting is taken only at a period boundary, so a reconfiguration during a transfer never produces a shortened pulse.

Top module: `sclk_duty_gen`

## Requirements
- R1: While running with a divisor value d of 2 or more, the clock and strobe pattern repeats every d system cycles. A divisor value of 0 is treated as 1.
- R2: The first phase of each period lasts H = floor((d*s + 128) / 256) system cycles, where s is the duty setting and a duty setting of 0 is used as 128.
- R3: For d of 2 or more, H is clamped to the range 1 to d-1.
- R4: The output level is the polarity input during the second phase and while idle, and its inverse during the first phase. Two clock edges after enable is sampled low, the clock rests at the polarity level and both strobes stay low. The first output cycle of a period appears two edges after enable is sampled high.
- R5: With phase = 0, the sample strobe is on the period-start edge and the launch strobe is on the edge that ends the first phase. With phase = 1, these two assignments are swapped.
- R6: Each period of a divisor of 2 or more carries exactly one launch strobe and one sample strobe, never in the same cycle. Each strobe falls in a cycle where the clock output changes level.
- R7: Divisor, duty, polarity and phase are captured only at the start of a period. Changes during a period take effect from the next period.
- R8: With a divisor of 0 or 1, the clock output is the system clock combined with the polarity: it is the inverse of polarity while the system clock is high. Both strobes are high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the serial clock while high |
| divisor | input | DIV_W | System cycles per bit period (0 behaves as 1) |
| duty | input | DUTY_W | First-phase length in 1/256 of the period (0 behaves as 128) |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Edge selection for sample and launch |
| sclk | output | 1 | Serial clock |
| launchStb | output | 1 | One-cycle strobe: drive the next bit |
| sampleStb | output | 1 | One-cycle strobe: capture the incoming bit |

## Verification
The assertions check four properties on every cycle. The idle level and quiet strobes must hold after a disable. Outside the fast mode, every strobe must coincide with a clock transition and launch and sample must never fall in the same cycle. Both strobes must be high throughout the fast mode. Captured settings must stay constant inside a period. Only the bench scenarios can show the exact numbers: the high-time arithmetic with its rounding and clamping, the period length for several divisors, and the edge assignment for each phase. They also show that a mid-period change lands exactly one boundary later and that the fast mode follows both levels of the system clock.

// File: rtl/sclk_duty_gen_pkg.sv
package sclk_duty_gen_pkg;

  // Per-cycle phase information handed from the control to the output stage.
  typedef struct packed {
    logic active;      // a period is being produced
    logic fast;        // divide-by-one mode
    logic lead;        // cycle that opens a period
    logic trail;       // cycle that ends the first phase
    logic firstPhase;  // inside the first phase
    logic pol;         // polarity captured for this period
    logic pha;         // phase captured for this period
  } phase_strobe_t;

endpackage

// File: rtl/sclk_phase_ctrl.sv
module sclk_phase_ctrl
  import sclk_duty_gen_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [DUTY_W-1:0] duty,
  input  logic              cpol,
  input  logic              cpha,
  output phase_strobe_t     stb
);

  localparam int PROD_W = DIV_W + DUTY_W;
  localparam logic [DUTY_W-1:0] HALF_DUTY = {1'b1, {(DUTY_W-1){1'b0}}};

  logic [DIV_W-1:0]  divEff;
  logic [DUTY_W-1:0] dutyEff;
  logic [PROD_W-1:0] prod;
  logic [DIV_W-1:0]  hiRaw;
  logic [DIV_W-1:0]  hiNext;

  logic              running;
  logic [DIV_W-1:0]  cnt;
  logic [DIV_W-1:0]  curDiv;
  logic [DIV_W-1:0]  curHigh;
  logic              curPol;
  logic              curPha;
  logic              periodEnd;

  // High-time arithmetic for the settings waiting at the inputs.
  always_comb begin
    divEff  = (divisor == '0) ? DIV_W'(1) : divisor;
    dutyEff = (duty == '0) ? HALF_DUTY : duty;
    prod    = PROD_W'(divEff) * PROD_W'(dutyEff) + PROD_W'(HALF_DUTY);
    hiRaw   = prod[PROD_W-1:DUTY_W];
    if (hiRaw == '0)
      hiNext = DIV_W'(1);
    else if (hiRaw >= divEff)
      hiNext = divEff - 1'b1;
    else
      hiNext = hiRaw;
  end

  assign periodEnd = (cnt == curDiv - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      curDiv  <= DIV_W'(1);
      curHigh <= '0;
      curPol  <= 1'b0;
      curPha  <= 1'b0;
    end else if (!enable) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running || periodEnd) begin
      running <= 1'b1;
      cnt     <= '0;
      curDiv  <= divEff;
      curHigh <= hiNext;
      curPol  <= cpol;
      curPha  <= cpha;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    stb.active     = running;
    stb.fast       = running && (curDiv == DIV_W'(1));
    stb.lead       = (cnt == '0);
    stb.trail      = (cnt == curHigh);
    stb.firstPhase = (cnt < curHigh);
    stb.pol        = curPol;
    stb.pha        = curPha;
  end

endmodule

// File: rtl/sclk_out_stage.sv
module sclk_out_stage
  import sclk_duty_gen_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  phase_strobe_t stb,
  input  logic          idlePol,
  output logic          sclkQ,
  output logic          launchQ,
  output logic          sampleQ,
  output logic          activeQ,
  output logic          fastQ,
  output logic          polQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      launchQ <= 1'b0;
      sampleQ <= 1'b0;
      activeQ <= 1'b0;
      fastQ   <= 1'b0;
      polQ    <= 1'b0;
    end else begin
      activeQ <= stb.active;
      fastQ   <= stb.fast;
      polQ    <= stb.active ? stb.pol : idlePol;
      if (!stb.active) begin
        sclkQ   <= idlePol;
        launchQ <= 1'b0;
        sampleQ <= 1'b0;
      end else if (stb.fast) begin
        sclkQ   <= stb.pol;
        launchQ <= 1'b1;
        sampleQ <= 1'b1;
      end else begin
        sclkQ   <= stb.pol ^ stb.firstPhase;
        launchQ <= stb.pha ? stb.lead  : stb.trail;
        sampleQ <= stb.pha ? stb.trail : stb.lead;
      end
    end
  end

endmodule

// File: rtl/sclk_duty_gen.sv
module sclk_duty_gen
  import sclk_duty_gen_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [DUTY_W-1:0] duty,
  input  logic              cpol,
  input  logic              cpha,
  output logic              sclk,
  output logic              launchStb,
  output logic              sampleStb
);

  phase_strobe_t stb;
  logic          sclkReg;
  logic          dpActive;
  logic          dpFast;
  logic          dpPol;

  sclk_phase_ctrl #(
    .DIV_W (DIV_W),
    .DUTY_W(DUTY_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .divisor(divisor),
    .duty   (duty),
    .cpol   (cpol),
    .cpha   (cpha),
    .stb    (stb)
  );

  sclk_out_stage u_out (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .idlePol(cpol),
    .sclkQ  (sclkReg),
    .launchQ(launchStb),
    .sampleQ(sampleStb),
    .activeQ(dpActive),
    .fastQ  (dpFast),
    .polQ   (dpPol)
  );

  // Divide-by-one passes the system clock, inverted by the captured polarity.
  assign sclk = dpFast ? (dpPol ^ clk) : sclkReg;

endmodule

// File: rtl/sclk_duty_gen_chk.sv
module sclk_duty_gen_chk
  import sclk_duty_gen_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          enable,
  input logic          cpol,
  input logic          sclk,
  input logic          launchStb,
  input logic          sampleStb,
  input phase_strobe_t stb,
  input logic          dpActive,
  input logic          dpFast,
  input logic          dpPol
);

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && $past(!enable) && $past(!enable, 2) && $past(rstN, 2))
      |-> (sclk == $past(cpol) && !launchStb && !sampleStb));

  // R6
  strobe_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpActive && $past(dpActive) && !dpFast && $past(!dpFast) && $stable(dpPol))
      |-> ((sclk != $past(sclk)) == (launchStb || sampleStb)));

  // R6
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpActive && !dpFast) |-> !(launchStb && sampleStb));

  // R8
  fast_strobes_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpFast |-> (launchStb && sampleStb));

  // R7
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.active && $past(stb.active) && !stb.lead)
      |-> ($stable(stb.pol) && $stable(stb.pha)));

endmodule

bind sclk_duty_gen sclk_duty_gen_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .cpol     (cpol),
  .sclk     (sclk),
  .launchStb(launchStb),
  .sampleStb(sampleStb),
  .stb      (stb),
  .dpActive (dpActive),
  .dpFast   (dpFast),
  .dpPol    (dpPol)
);

// File: tb/sim_sclk_duty_gen.sv
module sim_sclk_duty_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] divisor = 8'd4;
  logic [7:0] duty = 8'd128;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       sclk, launchStb, sampleStb;

  int checks = 0;
  int fails = 0;
  int seenLaunch = 0;
  int seenSample = 0;
  string curTag = "R1";
  logic [2:0] expQ[$];

  always #2.5 clk = ~clk;

  sclk_duty_gen u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .divisor(divisor), .duty(duty),
    .cpol(cpol), .cpha(cpha), .sclk(sclk), .launchStb(launchStb), .sampleStb(sampleStb)
  );

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual={sclk,launch,sample}=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Expected first-phase length from the rounding and clamp rules.
  function automatic int expHigh(int d, int s);
    int sv = (s == 0) ? 128 : s;
    int h = (d * sv + 128) / 256;
    if (h < 1) h = 1;
    if (h > d - 1) h = d - 1;
    return h;
  endfunction

  task automatic pushPeriods(int d, int s, bit pol, bit pha, int n);
    int h = expHigh(d, s);
    for (int p = 0; p < n; p++) begin
      for (int c = 0; c < d; c++) begin
        bit hi = (c < h);
        bit lead = (c == 0);
        bit trail = (c == h);
        expQ.push_back({pol ^ hi, pha ? lead : trail, pha ? trail : lead});
      end
    end
  endtask

  // Monitor: compare one expected item per cycle, away from the rising edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [2:0] e;
      e = expQ.pop_front();
      seenLaunch += int'(launchStb);
      seenSample += int'(sampleStb);
      check(curTag, {sclk, launchStb, sampleStb}, e);
    end
  end

  task automatic waitDrainAndStop(bit pol);
    while (expQ.size() != 0) @(negedge clk);
    enable = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R4 idle after disable", {sclk, launchStb, sampleStb}, {pol, 2'b00});
  endtask

  task automatic runCase(int d, int s, bit pol, bit pha, int n, string tag);
    @(negedge clk);
    divisor = 8'(d); duty = 8'(s); cpol = pol; cpha = pha;
    curTag = tag;
    seenLaunch = 0; seenSample = 0;
    @(negedge clk);
    enable = 1'b1;
    @(posedge clk);
    expQ.push_back({pol, 2'b00});   // datapath still idle after the first edge (R4)
    pushPeriods(d, s, pol, pha, n);
    while (expQ.size() != 0) @(negedge clk);
    checks++;
    if (seenLaunch != n || seenSample != n) begin
      fails++;
      $display("FAIL R6 strobe count actual=%0d/%0d expected=%0d/%0d", seenLaunch, seenSample, n, n);
    end
    waitDrainAndStop(pol);
  endtask

  task automatic runFast(int d, bit pol);
    @(negedge clk);
    divisor = 8'(d); cpol = pol; duty = 8'd77;
    @(negedge clk);
    enable = 1'b1;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check("R8 fast high half", {sclk, launchStb, sampleStb}, {~pol, 2'b11});
      @(negedge clk); #1;
      check("R8 fast low half", {sclk, launchStb, sampleStb}, {pol, 2'b11});
    end
    waitDrainAndStop(pol);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 reset state", {sclk, launchStb, sampleStb}, 3'b000);
    rstN = 1'b1;
    cpol = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R4 idle follows polarity", {sclk, launchStb, sampleStb}, 3'b100);

    runCase(4, 128, 1'b0, 1'b0, 3, "R1 R2 R5 d4 half");
    runCase(5, 0, 1'b1, 1'b1, 3, "R2 R4 R5 duty zero as half");
    runCase(4, 1, 1'b0, 1'b0, 2, "R3 clamp low");
    runCase(4, 255, 1'b0, 1'b1, 2, "R3 clamp high");
    runCase(10, 64, 1'b0, 1'b1, 2, "R1 R2 R5 d10 quarter");
    runCase(7, 200, 1'b1, 1'b0, 2, "R2 R6 d7");
    runCase(2, 128, 1'b1, 1'b1, 3, "R1 R3 d2");

    // R7: settings changed mid-period apply from the next boundary.
    @(negedge clk);
    divisor = 8'd4; duty = 8'd128; cpol = 1'b0; cpha = 1'b0;
    curTag = "R7 mid-period change";
    @(negedge clk);
    enable = 1'b1;
    @(posedge clk);
    expQ.push_back(3'b000);
    pushPeriods(4, 128, 1'b0, 1'b0, 1);
    pushPeriods(6, 64, 1'b1, 1'b1, 3);
    @(posedge clk);
    @(negedge clk);
    divisor = 8'd6; duty = 8'd64; cpol = 1'b1; cpha = 1'b1;
    waitDrainAndStop(1'b1);

    runFast(1, 1'b1);
    runFast(0, 1'b0);

    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    summary();
  end

endmodule